// File: doc/BRIEF.md
# Setup-Mode Command Line Parser

This block sits behind a byte-oriented serial receiver in a small radio data link. While the active-low setup input is held low, the radio link is switched off. Every received character is returned on an output byte strobe. Characters collect in a line buffer until a carriage return arrives. The completed line is then compared against a fixed, case-sensitive command vocabulary.

Recognised lines do one of three things. They change the volatile address or channel setting. They select a diagnostic transmit tone. Or they ask an external nonvolatile store to save the current address and channel as the new power-up defaults. After the store acknowledges, a single tilde character is sent to tell the host the save is complete. On reset the address and channel fall back to whatever the store presents as defaults. When setup is released, the tone selection is cleared and any partly typed line is discarded.

Top module: `setup_cmd_parser`

## Requirements
- R1: `radio_off` is 1 during reset. One cycle after each clock it equals the inverse of `setup_n` sampled at that clock.
- R2: A byte accepted with `rx_valid` high while `setup_n` is low appears on `tx_data` with `tx_valid` high one cycle later. Bytes offered while `setup_n` is high are not echoed.
- R3: Settings change only in the cycle after a carriage return (0x0D) is received. A complete command text without its carriage return changes nothing.
- R4: The line `ADDRd` with d from 0 to 7 sets `addr` to d. The line `CHANd` with d from 0 to 4 sets `chan` to d.
- R5: During reset `addr` and `chan` are 0. In the first cycle after reset they load `dflt_addr` and `dflt_chan`.
- R6: The line `SETPROGRAM` raises `store_req`, which carries the current address and channel on `store_addr` and `store_chan`. It holds until `store_ack`. After the acknowledge, one 0x7E byte is sent on the output stream, following the echo of the carriage return.
- R7: `tone` encodes 0 = off, 1 = unmodulated carrier, 2 = low square-wave modulation, 3 = high square-wave modulation. The line `NOTONE` selects 1, `LFTONE` selects 2, `HFTONE` selects 3, and `#` selects 0.
- R8: While `setup_n` is high, `tone` is forced to 0 and the line buffer is emptied. A line split across a setup exit does not execute.
- R9: A line that does not match, or that grows beyond 10 characters, is dropped at carriage return with no change to any output, and the buffer restarts empty.
- R10: Matching is case-sensitive. `ADDR8`, `ADDR9`, `CHAN5` to `CHAN9`, and a command followed by extra characters are all unrecognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_n | input | 1 | Setup mode request, active low |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Output byte strobe |
| tx_data | output | 8 | Output byte (echo or completion mark) |
| dflt_addr | input | 3 | Stored default address |
| dflt_chan | input | 3 | Stored default channel |
| store_req | output | 1 | Request to save defaults |
| store_addr | output | 3 | Address to be saved |
| store_chan | output | 3 | Channel to be saved |
| store_ack | input | 1 | Save complete, one-cycle pulse |
| addr | output | 3 | Current address |
| chan | output | 3 | Current channel |
| tone | output | 2 | Test tone selection |
| radio_off | output | 1 | Radio link disable |

## Verification
The properties assume four things about the environment. `store_ack` pulses for a single cycle and only while `store_req` is high. The stored defaults are always in range. Whatever consumes the output byte strobe accepts every byte without back-pressure. The bench's memory stub follows these rules: it answers each request exactly once after a fixed delay and then latches the saved values as its new defaults. Received bytes are spaced a few cycles apart, so each echo and the completion mark can be attributed to the line that produced them.

// File: rtl/setup_cmd_pkg.sv
package setup_cmd_pkg;

  typedef enum logic [1:0] {
    TONE_OFF = 2'd0,
    TONE_CW  = 2'd1,
    TONE_LF  = 2'd2,
    TONE_HF  = 2'd3
  } tone_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ADDR,
    CMD_CHAN,
    CMD_STORE,
    CMD_TONE
  } cmd_e;

  localparam int ARG_W = 3;

  typedef struct packed {
    cmd_e             kind;
    logic [ARG_W-1:0] arg;
    tone_e            tone;
  } cmd_t;

  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_TILDE = 8'h7E;

endpackage

// File: rtl/scp_line_buf.sv
module scp_line_buf #(
  parameter int LINE_MAX = 10,
  parameter int LEN_W    = $clog2(LINE_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  push,
  input  logic                  flush,
  input  logic [7:0]            din,
  output logic [8*LINE_MAX-1:0] line,
  output logic [LEN_W-1:0]      len,
  output logic                  ovf
);

  logic [LEN_W-1:0] len_q, len_d;
  logic             ovf_q, ovf_d;
  logic             room;

  assign room = int'(len_q) < LINE_MAX;

  always_comb begin
    len_d = len_q;
    ovf_d = ovf_q;
    if (clr || flush) begin
      len_d = '0;
      ovf_d = 1'b0;
    end else if (push) begin
      if (room) len_d = len_q + 1'b1;
      else      ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      len_q <= len_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar i = 0; i < LINE_MAX; i++) begin : g_slot
    logic [7:0] slot_q;
    logic       wr_en;
    assign wr_en = push && !clr && !flush && (int'(len_q) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q <= '0;
      else if (wr_en) slot_q <= din;
    end
    assign line[8*i +: 8] = slot_q;
  end

  assign len = len_q;
  assign ovf = ovf_q;

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(len_q) <= LINE_MAX); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || clr) |=> (len_q == '0) && !ovf_q); // R9

endmodule

// File: rtl/scp_decode.sv
module scp_decode
  import setup_cmd_pkg::*;
#(
  parameter int LINE_MAX = 10,
  parameter int LEN_W    = $clog2(LINE_MAX + 1),
  parameter int NUM_ADDR = 8,
  parameter int NUM_CHAN = 5
) (
  input  logic [8*LINE_MAX-1:0] line,
  input  logic [LEN_W-1:0]      len,
  input  logic                  ovf,
  output cmd_t                  cmd
);

  function automatic logic head_is(input logic [8*LINE_MAX-1:0] ln,
                                   input logic [79:0] pat, input int n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LINE_MAX; i++) begin
      if (i < n) begin
        if (ln[8*i +: 8] != pat[8*(n-1-i) +: 8]) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  function automatic logic line_is(input logic [8*LINE_MAX-1:0] ln,
                                   input logic [LEN_W-1:0] ll,
                                   input logic [79:0] pat, input int n);
    return (int'(ll) == n) && head_is(ln, pat, n);
  endfunction

  logic [7:0] dig;
  logic       dig_addr_ok, dig_chan_ok;

  assign dig         = line[39:32];
  assign dig_addr_ok = (int'(dig) >= 48) && (int'(dig) < 48 + NUM_ADDR);
  assign dig_chan_ok = (int'(dig) >= 48) && (int'(dig) < 48 + NUM_CHAN);

  always_comb begin
    cmd.kind = CMD_NONE;
    cmd.arg  = dig[ARG_W-1:0];
    cmd.tone = TONE_OFF;
    if (!ovf) begin
      if (line_is(line, len, "SETPROGRAM", 10)) begin
        cmd.kind = CMD_STORE;
      end else if (line_is(line, len, "NOTONE", 6)) begin
        cmd.kind = CMD_TONE;
        cmd.tone = TONE_CW;
      end else if (line_is(line, len, "LFTONE", 6)) begin
        cmd.kind = CMD_TONE;
        cmd.tone = TONE_LF;
      end else if (line_is(line, len, "HFTONE", 6)) begin
        cmd.kind = CMD_TONE;
        cmd.tone = TONE_HF;
      end else if (line_is(line, len, "#", 1)) begin
        cmd.kind = CMD_TONE;
      end else if (int'(len) == 5 && head_is(line, "ADDR", 4) && dig_addr_ok) begin
        cmd.kind = CMD_ADDR;
      end else if (int'(len) == 5 && head_is(line, "CHAN", 4) && dig_chan_ok) begin
        cmd.kind = CMD_CHAN;
      end
    end
  end

endmodule

// File: rtl/scp_tx_mux.sv
module scp_tx_mux
  import setup_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       echo_go,
  input  logic [7:0] echo_byte,
  input  logic       tilde_pend,
  output logic       tilde_take,
  output logic       tx_valid,
  output logic [7:0] tx_data
);

  logic       valid_d, valid_q;
  logic [7:0] data_d, data_q;

  assign tilde_take = tilde_pend && !echo_go;

  always_comb begin
    valid_d = echo_go || tilde_pend;
    data_d  = echo_go ? echo_byte : CH_TILDE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (valid_d) data_q <= data_d;
    end
  end

  assign tx_valid = valid_q;
  assign tx_data  = data_q;

  AST_ECHO_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    echo_go |=> tx_valid && (tx_data == $past(echo_byte))); // R2
  AST_MARK_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    tilde_take |=> tx_valid && (tx_data == CH_TILDE)); // R6

endmodule

// File: rtl/setup_cmd_parser.sv
module setup_cmd_parser
  import setup_cmd_pkg::*;
#(
  parameter int LINE_MAX = 10,
  parameter int NUM_ADDR = 8,
  parameter int NUM_CHAN = 5,
  parameter int ADDR_W   = 3,
  parameter int CHAN_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic [ADDR_W-1:0] dflt_addr,
  input  logic [CHAN_W-1:0] dflt_chan,
  output logic              store_req,
  output logic [ADDR_W-1:0] store_addr,
  output logic [CHAN_W-1:0] store_chan,
  input  logic              store_ack,
  output logic [ADDR_W-1:0] addr,
  output logic [CHAN_W-1:0] chan,
  output logic [1:0]        tone,
  output logic              radio_off
);

  localparam int LEN_W = $clog2(LINE_MAX + 1);

  logic                  rx_go, is_cr, push, flush;
  logic [8*LINE_MAX-1:0] line;
  logic [LEN_W-1:0]      len;
  logic                  ovf;
  cmd_t                  cmd;
  logic                  tilde_take;

  logic              init_q, init_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  tone_e             tone_q, tone_d;
  logic              roff_q, roff_d;
  logic              req_q, req_d;
  logic [ADDR_W-1:0] req_addr_q, req_addr_d;
  logic [CHAN_W-1:0] req_chan_q, req_chan_d;
  logic              pend_q, pend_d;

  assign rx_go = rx_valid && !setup_n;
  assign is_cr = (rx_data == CH_CR);
  assign push  = rx_go && !is_cr;
  assign flush = rx_go && is_cr;

  scp_line_buf #(.LINE_MAX(LINE_MAX), .LEN_W(LEN_W)) i_buf (
    .clk(clk), .rst_n(rst_n), .clr(setup_n), .push(push), .flush(flush),
    .din(rx_data), .line(line), .len(len), .ovf(ovf)
  );

  scp_decode #(.LINE_MAX(LINE_MAX), .LEN_W(LEN_W),
               .NUM_ADDR(NUM_ADDR), .NUM_CHAN(NUM_CHAN)) i_dec (
    .line(line), .len(len), .ovf(ovf), .cmd(cmd)
  );

  scp_tx_mux i_tx (
    .clk(clk), .rst_n(rst_n), .echo_go(rx_go), .echo_byte(rx_data),
    .tilde_pend(pend_q), .tilde_take(tilde_take),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  always_comb begin
    init_d     = 1'b1;
    addr_d     = addr_q;
    chan_d     = chan_q;
    tone_d     = tone_q;
    roff_d     = !setup_n;
    req_d      = req_q;
    req_addr_d = req_addr_q;
    req_chan_d = req_chan_q;
    pend_d     = pend_q && !tilde_take;
    if (!init_q) begin
      addr_d = dflt_addr;
      chan_d = dflt_chan;
    end else if (flush) begin
      case (cmd.kind)
        CMD_ADDR: addr_d = cmd.arg[ADDR_W-1:0];
        CMD_CHAN: chan_d = cmd.arg[CHAN_W-1:0];
        CMD_TONE: tone_d = cmd.tone;
        CMD_STORE: if (!req_q) begin
          req_d      = 1'b1;
          req_addr_d = addr_q;
          req_chan_d = chan_q;
        end
        default: ;
      endcase
    end
    if (setup_n) tone_d = TONE_OFF;
    if (req_q && store_ack) begin
      req_d  = 1'b0;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q     <= 1'b0;
      addr_q     <= '0;
      chan_q     <= '0;
      tone_q     <= TONE_OFF;
      roff_q     <= 1'b1;
      req_q      <= 1'b0;
      req_addr_q <= '0;
      req_chan_q <= '0;
      pend_q     <= 1'b0;
    end else begin
      init_q     <= init_d;
      addr_q     <= addr_d;
      chan_q     <= chan_d;
      tone_q     <= tone_d;
      roff_q     <= roff_d;
      req_q      <= req_d;
      req_addr_q <= req_addr_d;
      req_chan_q <= req_chan_d;
      pend_q     <= pend_d;
    end
  end

  assign addr       = addr_q;
  assign chan       = chan_q;
  assign tone       = tone_q;
  assign radio_off  = roff_q;
  assign store_req  = req_q;
  assign store_addr = req_addr_q;
  assign store_chan = req_chan_q;

  AST_RADIO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> (radio_off == $past(!setup_n))); // R1
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && !flush) |=> $stable(addr) && $stable(chan)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && !store_ack) |=> store_req && $stable(store_addr) && $stable(store_chan)); // R6
  AST_TONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    setup_n |=> (tone == 2'd0)); // R8

endmodule

// File: tb/test_setup_cmd_parser.sv
module test_setup_cmd_parser;

  logic       clk = 1'b0;
  logic       rst_n, setup_n, rx_valid, store_ack;
  logic [7:0] rx_data, tx_data;
  logic       tx_valid, store_req, radio_off;
  logic [2:0] stub_a, stub_c, store_addr, store_chan, addr, chan;
  logic [1:0] tone;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] log_b [64];
  int log_n = 0;

  always #10 clk = ~clk;

  setup_cmd_parser i_setup_cmd_parser (
    .clk(clk), .rst_n(rst_n), .setup_n(setup_n), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data),
    .dflt_addr(stub_a), .dflt_chan(stub_c), .store_req(store_req),
    .store_addr(store_addr), .store_chan(store_chan), .store_ack(store_ack),
    .addr(addr), .chan(chan), .tone(tone), .radio_off(radio_off)
  );

  always @(negedge clk) begin
    if (tx_valid && log_n < 64) begin
      log_b[log_n] = tx_data;
      log_n++;
    end
  end

  initial begin
    store_ack = 1'b0;
    stub_a    = 3'd0;
    stub_c    = 3'd0;
    forever begin
      @(negedge clk);
      if (store_req && !store_ack) begin
        repeat (3) @(negedge clk);
        stub_a    = store_addr;
        stub_c    = store_chan;
        store_ack = 1'b1;
        @(negedge clk);
        store_ack = 1'b0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = c;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_str(input logic [95:0] s);
    for (int i = 11; i >= 0; i--)
      if (s[8*i +: 8] != 8'h00) send_char(s[8*i +: 8]);
  endtask

  task automatic check_echo(input logic [95:0] s, input int extra);
    int k;
    int bad;
    k = 0;
    bad = 0;
    for (int i = 11; i >= 0; i--) begin
      if (s[8*i +: 8] != 8'h00) begin
        if (log_b[k] != s[8*i +: 8]) bad++;
        k++;
      end
    end
    if (log_b[k] != 8'h0D) bad++;
    check("R2 echo bytes", bad, 0);
    check("R2 echo count", log_n, k + 1 + extra);
  endtask

  localparam int NV = 15;
  localparam logic [95:0] V_STR [NV] = '{
    "ADDR5", "CHAN3", "LFTONE", "HFTONE", "NOTONE", "#", "ADDR7", "CHAN4",
    "ADDR8", "CHAN5", "chan2", "ADDR55", "SETPROGRAMX", "CHAN0", "ADDR2"};
  localparam int V_A [NV] = '{5, 5, 5, 5, 5, 5, 7, 7, 7, 7, 7, 7, 7, 7, 2};
  localparam int V_C [NV] = '{0, 3, 3, 3, 3, 3, 3, 4, 4, 4, 4, 4, 4, 0, 0};
  localparam int V_T [NV] = '{0, 0, 2, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    setup_n  = 1'b0;
    rx_valid = 1'b0;
    rx_data  = 8'h00;
    repeat (3) @(negedge clk);
    check("R5 reset addr", addr, 0);
    check("R5 reset chan", chan, 0);
    check("R7 reset tone", tone, 0);
    check("R1 reset radio_off", radio_off, 1);
    check("R6 reset store_req", store_req, 0);
    check("R2 reset tx_valid", tx_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 setup radio_off", radio_off, 1);

    // vector walk: R4 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      log_n = 0;
      send_str(V_STR[v]);
      send_char(8'h0D);
      check("R4 R9 R10 addr", addr, V_A[v]);
      check("R4 R9 R10 chan", chan, V_C[v]);
      check("R7 tone", tone, V_T[v]);
      check("R9 no store", store_req, 0);
      check_echo(V_STR[v], 0);
    end

    // R3: complete text without carriage return
    send_str("ADDR6");
    check("R3 no exec before CR", addr, 2);
    send_char(8'h0D);
    check("R3 exec on CR", addr, 6);

    // R6: store and completion mark
    log_n = 0;
    send_str("SETPROGRAM");
    send_char(8'h0D);
    repeat (10) @(negedge clk);
    check_echo("SETPROGRAM", 1);
    check("R6 mark after CR echo", log_b[11], 8'h7E);
    check("R6 stored addr", stub_a, 6);
    check("R6 stored chan", stub_c, 0);
    check("R6 req dropped", store_req, 0);

    // R5: volatile value lost, defaults reloaded
    send_str("ADDR1");
    send_char(8'h0D);
    check("R4 addr1", addr, 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R5 addr in reset", addr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 addr reload", addr, 6);
    check("R5 chan reload", chan, 0);

    // R8 / R1: leaving setup
    send_str("LFTONE");
    send_char(8'h0D);
    check("R7 lf tone", tone, 2);
    setup_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 tone cleared", tone, 0);
    check("R1 radio on", radio_off, 0);
    log_n = 0;
    send_str("ADDR1");
    send_char(8'h0D);
    check("R2 no echo outside setup", log_n, 0);
    check("R8 ignored outside setup", addr, 6);
    setup_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 radio off again", radio_off, 1);

    // R8: partial line does not survive a setup exit
    send_str("ADD");
    setup_n = 1'b1;
    repeat (2) @(negedge clk);
    setup_n = 1'b0;
    repeat (2) @(negedge clk);
    send_str("R3");
    send_char(8'h0D);
    check("R8 split line dropped", addr, 6);
    send_str("ADDR3");
    send_char(8'h0D);
    check("R9 buffer restarts", addr, 3);

    finish_run();
  end

endmodule